// File: doc/BRIEF.md
# Register Window Spill and Fill Sequencer

This block handles register-window overflow and underflow traps in hardware. A trap does not jump to a software handler. The core raises a start request that gives the kind of operation and its current window pointer. The sequencer then moves one window's sixteen local and in registers between the register file and a 64-byte block on the stack. It moves them as eight 64-bit memory transfers. When the transfers finish, it rotates the invalid-window mask one place and pulses done. The core then replays the save or restore that faulted.

The block owns the invalid-window mask. It reaches windows other than the current one through a side port into the windowed register file. It finds each block's stack pointer by reading register 14 as seen from the window being moved. A flush operation writes every caller window to its own stack block and leaves the current window as the only valid one.

A memory error response stops the operation at once. The mask keeps its old value and a fault pulse replaces the done pulse.

Top module: `rwsf_top`

## Requirements
- R1: After reset, busy, trap_done, trap_fault, mem_req and rf_we are 0, and inv_mask is one-hot at bit RST_INV (8'h02 with the defaults).
- R2: A spill (trap_op 0, overflow) with current window c moves window (c-2) mod NWIN. The window that is moved is the one next to the invalid window on the save side. Its stack pointer is the upper half of the pair that the side port returns for rf_win = that window and rf_idx = 14.
- R3: A window moves as eight beats k = 0..7, in increasing order. Beat k has address sp + 8k and carries registers 16+2k and 17+2k. The even register sits in bits [63:32] and the odd register in bits [31:0]. A spill writes (mem_we 1) the data that the side port returns for rf_idx = 16+2k.
- R4: A completed spill rotates the mask right by one place: the invalid bit moves from window w to window (w-1) mod NWIN.
- R5: A fill (trap_op 1, underflow) with current window c loads window (c+1) mod NWIN (mem_we 0). It writes each acknowledged beat into the register pair through rf_we, and when it completes it rotates the mask left by one place.
- R6: inv_mask reads all zeros from the cycle after a start is accepted until the operation ends, so no window trap can be raised meanwhile.
- R7: trap_done is high for exactly one cycle, in the cycle after the final acknowledge. busy is low in that same cycle and inv_mask shows the new mask.
- R8: A mem_err response stops the operation. trap_fault pulses for one cycle in place of trap_done, no further request follows, and the mask keeps its value from before the operation.
- R9: A flush (trap_op 2) spills windows c+1, c+2, … up to the window just below the invalid one, in that order, each using its own stack pointer. It then sets the mask one-hot at (c+1) mod NWIN. If there are no such windows, trap_done pulses in the next cycle and there is no memory traffic.
- R10: A start request is ignored while busy is high. trap_op value 3 is never driven.
- R11: After acceptance there is one cycle with no request, in which the stack pointer is read. mem_req then rises, and while it waits for a response it holds mem_addr, mem_we and the spill data steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trap_start | input | 1 | Start request, sampled while idle |
| trap_op | input | 2 | 0 spill, 1 fill, 2 flush |
| trap_cwp | input | WW | Current window pointer of the core |
| trap_done | output | 1 | One-cycle completion pulse |
| trap_fault | output | 1 | One-cycle abort pulse after a memory error |
| busy | output | 1 | Operation in progress |
| inv_mask | output | NWIN | Invalid-window mask, zero while busy |
| rf_win | output | WW | Window addressed on the side port |
| rf_idx | output | 5 | Even register number within that window |
| rf_rdata | input | 2*XLEN | {r[idx], r[idx+1]}, combinational read |
| rf_we | output | 1 | Write the pair at rf_win/rf_idx |
| rf_wdata | output | 2*XLEN | Pair data to write |
| mem_req | output | 1 | Memory request, held until ack or err |
| mem_we | output | 1 | 1 store, 0 load |
| mem_addr | output | XLEN | Byte address of the beat |
| mem_wdata | output | 2*XLEN | Store data |
| mem_ack | input | 1 | Transfer complete |
| mem_err | input | 1 | Transfer failed |
| mem_rdata | input | 2*XLEN | Load data, valid with mem_ack |

## Verification
The assertions assume the following about the inputs. Memory answers only while mem_req is high, and never raises ack and err in the same cycle. The register file changes only through rf_we, so a spill beat that is waiting sees steady data. Reset holds trap_start low. The bench keeps to these rules: its memory responder answers only the request that is pending, after a latency that varies from 0 to 3 cycles, and it gives a single response each time. Its register file model is written only by the block's write port while an operation runs. Its reference model tracks the mask, the queue of expected beats and the pulses on every clock.

// File: rtl/rwsf_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the window spill/fill sequencer.
// Assumes a 24-register window with 8 locals at 16..23 and 8 ins at 24..31.
package rwsf_pkg;
    typedef enum logic [1:0] {
        OP_SPILL = 2'd0,
        OP_FILL  = 2'd1,
        OP_FLUSH = 2'd2
    } rwsf_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPGET = 2'd1,
        ST_MOVE  = 2'd2
    } rwsf_st_e;

    localparam int unsigned BEATS     = 8;   // register pairs per window
    localparam int unsigned PAIR_BASE = 16;  // first local register
    localparam int unsigned SP_REG    = 14;  // stack pointer register
endpackage

// File: rtl/rwsf_mask.sv
`timescale 1ns/1ps
// Holds the invalid-window mask and computes its next value on commit.
// Assumes the mask stays one-hot; reports the index of the invalid window.
module rwsf_mask
    import rwsf_pkg::*;
#(
    parameter int unsigned NWIN    = 8,
    parameter int unsigned RST_INV = 1,
    localparam int unsigned WW     = (NWIN > 2) ? $clog2(NWIN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  rwsf_op_e        cmt_op,
    input  logic [WW-1:0]   cmt_cwp,
    output logic [NWIN-1:0] mask_q,
    output logic [WW-1:0]   inv_idx
);
    logic [NWIN-1:0] rot_r, rot_l, fl_mask, mask_d;
    logic [WW-1:0]   cwp_p1;

    // Wrap-around rotations by one window in either direction.
    for (genvar i = 0; i < NWIN; i++) begin : g_rot
        assign rot_r[i] = mask_q[(i + 1) % NWIN];
        assign rot_l[i] = mask_q[(i + NWIN - 1) % NWIN];
    end

    // One-hot mask just above the current window, used after a flush.
    always_comb begin
        cwp_p1  = (cmt_cwp == WW'(NWIN - 1)) ? '0 : cmt_cwp + 1'b1;
        fl_mask = '0;
        fl_mask[cwp_p1] = 1'b1;
    end

    // Select the next mask from the operation being committed.
    always_comb begin
        unique case (cmt_op)
            OP_SPILL: mask_d = rot_r;
            OP_FILL:  mask_d = rot_l;
            default:  mask_d = fl_mask;
        endcase
    end

    // Mask register; changes only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q          <= '0;
            mask_q[RST_INV] <= 1'b1;
        end else if (commit) begin
            mask_q <= mask_d;
        end
    end

    // Encode the position of the invalid bit.
    always_comb begin
        inv_idx = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (mask_q[i]) inv_idx = WW'(i);
        end
    end

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mask_q));
    assert_mask_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(mask_q));
endmodule

// File: rtl/rwsf_beat.sv
`timescale 1ns/1ps
// Latches the stack pointer of the window being moved and forms the
// byte address and register pair of each beat. Assumes 8-byte beats.
module rwsf_beat
    import rwsf_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    localparam int unsigned BW  = $clog2(BEATS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sp_load,
    input  logic [XLEN-1:0] sp_in,
    input  logic [BW-1:0]   beat,
    output logic [XLEN-1:0] addr,
    output logic [4:0]      pair_idx
);
    logic [XLEN-1:0] sp_q;

    // Capture the stack pointer during the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       sp_q <= '0;
        else if (sp_load) sp_q <= sp_in;
    end

    // Beat k sits at sp + 8k and carries registers 16+2k and 17+2k.
    always_comb begin
        addr     = sp_q + (XLEN'(beat) << 3);
        pair_idx = 5'(PAIR_BASE + 2 * int'(beat));
    end
endmodule

// File: rtl/rwsf_ctrl.sv
`timescale 1ns/1ps
// Sequencer state machine: accepts a start, selects the target window,
// steps through the stack-pointer read and eight beats per window,
// and issues commit, done and fault. Assumes ack and err are exclusive.
module rwsf_ctrl
    import rwsf_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned WW  = (NWIN > 2) ? $clog2(NWIN) : 1,
    localparam int unsigned BW  = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_in,
    input  logic [WW-1:0] cwp_in,
    input  logic [WW-1:0] inv_idx,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          busy,
    output logic          sp_load,
    output logic          moving,
    output logic [BW-1:0] beat,
    output logic [WW-1:0] win,
    output rwsf_op_e      op_q,
    output logic          commit,
    output rwsf_op_e      cmt_op,
    output logic [WW-1:0] cmt_cwp,
    output logic          done,
    output logic          fault,
    output logic          rf_we
);
    rwsf_st_e      state;
    logic [BW-1:0] beat_q;
    logic [WW-1:0] win_q, left_q, cwp_q, fl_cnt;
    logic          done_q, fault_q, start_ok, last_beat, fin_ok;
    rwsf_op_e      op_new;

    // Add a distance to a window number, modulo the window count.
    function automatic logic [WW-1:0] wadd(input logic [WW-1:0] a, input int unsigned d);
        int unsigned s;
        s = (int'(a) + d) % NWIN;
        return WW'(s);
    endfunction

    // Decode start and the number of caller windows a flush must spill.
    always_comb begin
        op_new    = rwsf_op_e'(op_in);
        start_ok  = (state == ST_IDLE) && start && (op_in != 2'd3);
        fl_cnt    = WW'((int'(inv_idx) + NWIN - int'(cwp_in) - 1) % NWIN);
        last_beat = (beat_q == BW'(BEATS - 1));
        fin_ok    = (state == ST_MOVE) && mem_ack && !mem_err;
    end

    // Commit strobe and the operation/window it applies to.
    always_comb begin
        commit  = (start_ok && op_new == OP_FLUSH && fl_cnt == '0)
               || (fin_ok && last_beat && left_q == '0);
        cmt_op  = (state == ST_IDLE) ? op_new : op_q;
        cmt_cwp = (state == ST_IDLE) ? cwp_in : cwp_q;
    end

    // Main sequence: idle, stack-pointer read, beat transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            beat_q  <= '0;
            win_q   <= '0;
            left_q  <= '0;
            cwp_q   <= '0;
            op_q    <= OP_SPILL;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        op_q   <= op_new;
                        cwp_q  <= cwp_in;
                        beat_q <= '0;
                        left_q <= '0;
                        if (op_new == OP_SPILL) begin
                            win_q <= wadd(cwp_in, NWIN - 2);
                            state <= ST_SPGET;
                        end else if (op_new == OP_FILL) begin
                            win_q <= wadd(cwp_in, 1);
                            state <= ST_SPGET;
                        end else if (fl_cnt == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            win_q  <= wadd(cwp_in, 1);
                            left_q <= fl_cnt - 1'b1;
                            state  <= ST_SPGET;
                        end
                    end
                end
                ST_SPGET: state <= ST_MOVE;
                ST_MOVE: begin
                    if (mem_err) begin
                        fault_q <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            if (left_q == '0) begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                left_q <= left_q - 1'b1;
                                win_q  <= wadd(win_q, 1);
                                state  <= ST_SPGET;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        busy    = (state != ST_IDLE);
        sp_load = (state == ST_SPGET);
        moving  = (state == ST_MOVE);
        beat    = beat_q;
        win     = win_q;
        done    = done_q;
        fault   = fault_q;
        rf_we   = fin_ok && (op_q == OP_FILL);
    end

    assert_err_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && mem_err) |=> (fault && !done && !busy));
    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start_ok || (moving && mem_ack)));
endmodule

// File: rtl/rwsf_top.sv
`timescale 1ns/1ps
// Window spill/fill sequencer top: wires the controller, beat generator
// and mask holder to the register-file side port and the memory port.
// Assumes a combinational side-port read and a held request/response bus.
module rwsf_top
    import rwsf_pkg::*;
#(
    parameter int unsigned NWIN    = 8,
    parameter int unsigned XLEN    = 32,
    parameter int unsigned RST_INV = 1,
    localparam int unsigned WW     = (NWIN > 2) ? $clog2(NWIN) : 1,
    localparam int unsigned DW     = 2 * XLEN,
    localparam int unsigned BW     = $clog2(BEATS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_start,
    input  logic [1:0]      trap_op,
    input  logic [WW-1:0]   trap_cwp,
    output logic            trap_done,
    output logic            trap_fault,
    output logic            busy,
    output logic [NWIN-1:0] inv_mask,
    output logic [WW-1:0]   rf_win,
    output logic [4:0]      rf_idx,
    input  logic [DW-1:0]   rf_rdata,
    output logic            rf_we,
    output logic [DW-1:0]   rf_wdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic            mem_err,
    input  logic [DW-1:0]   mem_rdata
);
    logic            sp_load, moving, commit;
    logic [BW-1:0]   beat;
    logic [WW-1:0]   win, cmt_cwp, inv_idx;
    logic [4:0]      pair_idx;
    logic [NWIN-1:0] mask_q;
    rwsf_op_e        op_q, cmt_op;

    rwsf_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(trap_start), .op_in(trap_op),
        .cwp_in(trap_cwp), .inv_idx(inv_idx), .mem_ack(mem_ack), .mem_err(mem_err),
        .busy(busy), .sp_load(sp_load), .moving(moving), .beat(beat), .win(win),
        .op_q(op_q), .commit(commit), .cmt_op(cmt_op), .cmt_cwp(cmt_cwp),
        .done(trap_done), .fault(trap_fault), .rf_we(rf_we)
    );

    rwsf_beat #(.XLEN(XLEN)) u_beat (
        .clk(clk), .rst_n(rst_n), .sp_load(sp_load),
        .sp_in(rf_rdata[DW-1 -: XLEN]), .beat(beat),
        .addr(mem_addr), .pair_idx(pair_idx)
    );

    rwsf_mask #(.NWIN(NWIN), .RST_INV(RST_INV)) u_mask (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cmt_op(cmt_op),
        .cmt_cwp(cmt_cwp), .mask_q(mask_q), .inv_idx(inv_idx)
    );

    // Port routing: side port address, data paths and the masked trap view.
    always_comb begin
        rf_win    = win;
        rf_idx    = moving ? pair_idx : 5'(SP_REG);
        rf_wdata  = mem_rdata;
        mem_req   = moving;
        mem_we    = (op_q != OP_FILL);
        mem_wdata = rf_rdata;
        inv_mask  = busy ? '0 : mask_q;
    end

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && (!mem_we || $stable(mem_wdata))));
    assert_rf_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_req && mem_ack && !mem_we));
    assert_done_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_done && trap_fault));
endmodule

// File: tb/sim_rwsf_top.sv
`timescale 1ns/1ps
// Bench: behavioural register file and memory, a queue-based reference
// model compared on every clock, and directed operation sequences.
module sim_rwsf_top;
    localparam int N  = 8;
    localparam int X  = 32;
    localparam int WW = 3;
    localparam int WD = 20000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, trap_start, trap_done, trap_fault, busy, rf_we;
    logic [1:0] trap_op;
    logic [WW-1:0] trap_cwp, rf_win;
    logic [N-1:0] inv_mask;
    logic [4:0] rf_idx;
    logic [2*X-1:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;
    logic mem_req, mem_we, mem_ack, mem_err;
    logic [X-1:0] mem_addr;

    rwsf_top u0 (.*);

    // ---- register file model: globals then 16 registers per window ----
    logic [X-1:0] prf [0:8+16*N-1];
    function automatic int pidx(int w, int r);
        if (r < 8)  return r;
        if (r < 16) return 8 + 16*((w+N-1)%N) + 8 + (r-8);
        if (r < 24) return 8 + 16*w + (r-16);
        return 8 + 16*w + 8 + (r-24);
    endfunction
    always_comb rf_rdata = {prf[pidx(int'(rf_win), int'(rf_idx))], prf[pidx(int'(rf_win), int'(rf_idx)+1)]};
    always @(posedge clk) if (rf_we) begin
        prf[pidx(int'(rf_win), int'(rf_idx))]   <= rf_wdata[2*X-1:X];
        prf[pidx(int'(rf_win), int'(rf_idx)+1)] <= rf_wdata[X-1:0];
    end

    // ---- memory model ----
    logic [63:0] mem [int unsigned];
    function automatic logic [63:0] mread(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return {a, ~a};
    endfunction

    // ---- reference model ----
    typedef struct { logic [31:0] a; logic we; logic [63:0] d; bit last; } xfer_t;
    xfer_t xq[$];
    int m_st;                       // 0 idle, 1 stack-pointer read, 2 transfers
    logic [N-1:0] m_mask, m_new;
    bit m_busy, m_req, m_done, m_fault;

    int nchk, nerr, cyc, lat, nbeat, err_at;
    bit wd_hit, go_pend, saw_done, saw_fault;
    logic [1:0] go_op;
    logic [WW-1:0] go_cwp;
    logic [31:0] first_addr;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] spof(int w);
        return prf[pidx(w, 14)];
    endfunction

    task automatic add_win(int w, bit spill);
        logic [31:0] sp = spof(w);
        for (int k = 0; k < 8; k++) begin
            xfer_t t;
            t.a = sp + 32'(8*k);
            t.we = spill;
            t.d = spill ? {prf[pidx(w,16+2*k)], prf[pidx(w,17+2*k)]} : mread(sp + 32'(8*k));
            t.last = (k == 7);
            xq.push_back(t);
        end
    endtask

    function automatic int inv_of(logic [N-1:0] m);
        int r = 0;
        for (int i = 0; i < N; i++) if (m[i]) r = i;
        return r;
    endfunction

    task automatic step();
        bit started, lastb;
        @(negedge clk);
        cyc++;
        if (cyc > WD && !wd_hit) begin
            wd_hit = 1; nerr++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
        end
        // compare outputs with the model
        chk(busy == m_busy, "R7", "busy", 64'(busy), 64'(m_busy));
        chk(trap_done == m_done, "R7", "done", 64'(trap_done), 64'(m_done));
        chk(trap_fault == m_fault, "R8", "fault", 64'(trap_fault), 64'(m_fault));
        chk(inv_mask == (m_busy ? '0 : m_mask), "R6", "inv_mask", 64'(inv_mask), 64'(m_busy ? '0 : m_mask));
        chk(mem_req == m_req, "R11", "mem_req", 64'(mem_req), 64'(m_req));
        if (trap_done) saw_done = 1;
        if (trap_fault) saw_fault = 1;
        if (mem_req && m_req && xq.size() > 0) begin
            chk(mem_addr == xq[0].a, "R3", "mem_addr", 64'(mem_addr), 64'(xq[0].a));
            chk(mem_we == xq[0].we, "R3", "mem_we", 64'(mem_we), 64'(xq[0].we));
            if (xq[0].we) chk(mem_wdata == xq[0].d, "R3", "mem_wdata", mem_wdata, xq[0].d);
        end
        // drive inputs for the next edge
        trap_start = 0; mem_ack = 0; mem_err = 0; started = 0;
        if (go_pend) begin
            trap_start = 1; trap_op = go_op; trap_cwp = go_cwp; go_pend = 0;
            started = (m_st == 0);
        end
        if (m_st == 2 && xq.size() > 0) begin
            if (lat == 0) begin
                if (nbeat == 0) first_addr = mem_addr;
                if (nbeat == err_at) mem_err = 1;
                else begin
                    mem_ack = 1;
                    if (xq[0].we) mem[xq[0].a] = mem_wdata;
                    else mem_rdata = mread(xq[0].a);
                end
                lat = (nbeat * 3 + 1) % 4;
                nbeat++;
            end else lat--;
        end
        // advance the model across the edge
        m_done = 0; m_fault = 0;
        case (m_st)
            0: if (started) begin
                int c = int'(go_cwp);
                if (go_op == 2'd0) begin
                    add_win((c+N-2)%N, 1); m_new = {m_mask[0], m_mask[N-1:1]}; m_st = 1;
                end else if (go_op == 2'd1) begin
                    add_win((c+1)%N, 0); m_new = {m_mask[N-2:0], m_mask[N-1]}; m_st = 1;
                end else begin
                    int cnt = (inv_of(m_mask) + N - c - 1) % N;
                    for (int j = 0; j < cnt; j++) add_win((c+1+j)%N, 1);
                    m_new = '0; m_new[(c+1)%N] = 1'b1;
                    if (cnt == 0) begin m_done = 1; m_mask = m_new; end
                    else m_st = 1;
                end
            end
            1: m_st = 2;
            default: begin
                if (mem_err) begin
                    m_fault = 1; m_st = 0; xq.delete();
                end else if (mem_ack) begin
                    lastb = xq[0].last;
                    void'(xq.pop_front());
                    if (xq.size() == 0) begin m_done = 1; m_st = 0; m_mask = m_new; end
                    else if (lastb) m_st = 1;
                end
            end
        endcase
        m_busy = (m_st != 0);
        m_req  = (m_st == 2);
    endtask

    task automatic run_op(logic [1:0] op, int c, int eb, bit poke);
        int n = 0;
        go_pend = 1; go_op = op; go_cwp = WW'(c);
        nbeat = 0; err_at = eb; lat = 0; saw_done = 0; saw_fault = 0;
        step();
        while (m_st != 0 && !wd_hit) begin
            n++;
            if (poke && n == 4) begin go_pend = 1; go_op = 2'd1; go_cwp = 3'd5; end
            step();
        end
        step();
    endtask

    task automatic check_spilled(int w, string req);
        logic [31:0] sp = spof(w);
        for (int k = 0; k < 8; k++)
            chk(mread(sp + 32'(8*k)) == {prf[pidx(w,16+2*k)], prf[pidx(w,17+2*k)]}, req,
                "stack block", mread(sp + 32'(8*k)), {prf[pidx(w,16+2*k)], prf[pidx(w,17+2*k)]});
    endtask

    logic [31:0] snap [16];

    initial begin
        rst_n = 0; trap_start = 0; trap_op = 0; trap_cwp = 0;
        mem_ack = 0; mem_err = 0; mem_rdata = '0; go_pend = 0; go_op = 0; go_cwp = 0;
        nchk = 0; nerr = 0; cyc = 0; wd_hit = 0; err_at = -1; first_addr = 0;
        m_st = 0; m_mask = 8'h02; m_new = 8'h02; m_busy = 0; m_req = 0; m_done = 0; m_fault = 0;
        for (int i = 0; i < 8+16*N; i++) prf[i] <= 32'hA500_0000 + 32'(i * 32'h0101);
        for (int w = 0; w < N; w++) prf[pidx(w,14)] <= 32'h0001_0000 + 32'(w * 32'h200);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(busy == 0 && trap_done == 0 && trap_fault == 0, "R1", "status", {busy, trap_done, trap_fault}, 0);
        chk(mem_req == 0 && rf_we == 0, "R1", "req/we", {mem_req, rf_we}, 0);
        chk(inv_mask == 8'h02, "R1", "inv_mask", 64'(inv_mask), 64'h02);

        // R2/R3/R4: overflow at cwp 2 spills window 0
        run_op(2'd0, 2, -1, 0);
        chk(first_addr == spof(0), "R2", "first beat address", 64'(first_addr), 64'(spof(0)));
        check_spilled(0, "R3");
        chk(inv_mask == 8'h01, "R4", "mask after spill", 64'(inv_mask), 64'h01);
        chk(saw_done, "R7", "done seen", 64'(saw_done), 1);

        // R5: corrupt window 0, then underflow at cwp 7 fills it back
        for (int r = 16; r < 32; r++) begin
            snap[r-16] = prf[pidx(0,r)];
            prf[pidx(0,r)] <= 32'hDEAD_0000 + 32'(r);
        end
        step();
        run_op(2'd1, 7, -1, 0);
        for (int r = 16; r < 32; r++)
            chk(prf[pidx(0,r)] == snap[r-16], "R5", "filled register", 64'(prf[pidx(0,r)]), 64'(snap[r-16]));
        chk(inv_mask == 8'h02, "R5", "mask after fill", 64'(inv_mask), 64'h02);

        // R8: error on beat 3 aborts, mask kept
        run_op(2'd0, 2, 3, 0);
        chk(saw_fault && !saw_done, "R8", "fault without done", {saw_fault, saw_done}, 2'b10);
        chk(inv_mask == 8'h02, "R8", "mask unchanged", 64'(inv_mask), 64'h02);

        // R10: start during busy is ignored
        run_op(2'd0, 2, -1, 1);
        chk(nbeat == 8, "R10", "beats in one op", 64'(nbeat), 8);
        chk(inv_mask == 8'h01, "R10", "mask after poked spill", 64'(inv_mask), 64'h01);

        // two more overflows walk the invalid window down to 6
        run_op(2'd0, 1, -1, 0);
        chk(inv_mask == 8'h80, "R4", "mask wraps", 64'(inv_mask), 64'h80);
        run_op(2'd0, 0, -1, 0);
        chk(inv_mask == 8'h40, "R4", "mask after third spill", 64'(inv_mask), 64'h40);

        // R9: flush at cwp 2 spills windows 3, 4, 5
        run_op(2'd2, 2, -1, 0);
        chk(nbeat == 24, "R9", "flush beats", 64'(nbeat), 24);
        chk(inv_mask == 8'h08, "R9", "mask after flush", 64'(inv_mask), 64'h08);
        for (int w = 3; w < 6; w++) check_spilled(w, "R9");

        // R9: flush with nothing to spill
        run_op(2'd2, 2, -1, 0);
        chk(nbeat == 0, "R9", "empty flush beats", 64'(nbeat), 0);
        chk(saw_done, "R9", "empty flush done", 64'(saw_done), 1);
        chk(inv_mask == 8'h08, "R9", "mask after empty flush", 64'(inv_mask), 64'h08);

        // R5: underflow at cwp 2 fills window 3, mask moves up to 4
        run_op(2'd1, 2, -1, 0);
        chk(inv_mask == 8'h10, "R5", "mask after second fill", 64'(inv_mask), 64'h10);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule